// File: doc/BRIEF.md
# Instruction Length Decoder

This block looks at the lowest 16-bit parcel of an instruction and states at once how many 16-bit parcels the whole instruction occupies. One pass of logic covers every length from one parcel (16 bits) to eleven parcels (176 bits). No walk over successive bytes is needed. A fetch unit or an instruction aligner uses the count to find where the next instruction starts.

Besides the count, the block marks short (compressed) instructions. It also marks the reserved encoding space meant for 192 bits and beyond. An illegal flag is raised for three cases: a reserved encoding, a length beyond the configured maximum instruction width `ILEN`, or a short instruction when compressed support is switched off. A parameter inserts one output register stage. By default the block is purely combinational.

Top module: `ild_top`

## Requirements
- R1: When parcel bits [1:0] differ from 2'b11, the length is 1 parcel and the compressed flag is 1.
- R2: When bits [1:0] are 2'b11 and bits [4:2] differ from 3'b111, the length is 2 parcels and the compressed flag is 0.
- R3: Bits [5:0] equal to 6'b011111 give 3 parcels. Bits [6:0] equal to 7'b0111111 give 4 parcels.
- R4: Bits [6:0] equal to 7'b1111111 with bits [14:12] holding n, where n is 0 to 6, give 5+n parcels.
- R5: Bits [6:0] equal to 7'b1111111 with bits [14:12] equal to 3'b111 set the reserved flag and the illegal flag, and report a length of 0.
- R6: A decoded length of more than ILEN/16 parcels sets the illegal flag, and the length is still reported. A length within the limit with no other fault leaves the illegal flag at 0.
- R7: With COMPRESSED_EN = 0, a 1-parcel encoding sets the illegal flag while still reporting length 1 and the compressed flag.
- R8: With OUT_REG = 0, the valid output equals the valid input in the same cycle. While valid is 0, the length and all flags are 0.
- R9: With OUT_REG = 1, every output appears one clock after its input. Reset clears all outputs.
- R10: Parcel bits that do not take part in the length rule for a given encoding have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the optional output register) |
| rstN | input | 1 | Asynchronous active-low reset |
| parcelIn | input | 16 | Lowest parcel of the instruction |
| parcelValid | input | 1 | parcelIn holds a parcel to decode |
| lenParcels | output | 4 | Instruction length in 16-bit parcels, 0 when reserved or idle |
| isCompressed | output | 1 | Single-parcel encoding |
| isReserved | output | 1 | Encoding lies in the reserved long-length space |
| isIllegal | output | 1 | Reserved, longer than ILEN, or short with compressed support off |
| lenValid | output | 1 | Outputs describe a valid parcel |

## Verification
Two of the block's functions can act on the same parcel. The length ladder can produce a count while the ILEN limit, or the reserved rule, raises the illegal flag. The bench provokes this with long encodings (5, 6 and 11 parcels, and n = 7) at the default ILEN of 64 bits. It checks that the count and the illegal flag are both right together. A second instance with ILEN of 176 bits, compressed support off and the register stage on shows the same encodings as legal. It shows the short encodings as illegal while they still keep their count, and the bench judges each result one clock after the drive.

// File: rtl/ild_pkg.sv
package ild_pkg;
  localparam int PARCEL_W   = 16;
  localparam int LADDER_MAX = 11;
  localparam int LEN_W      = $clog2(LADDER_MAX + 1);

  // classification strobes from control to datapath
  typedef struct packed {
    logic       isShort;
    logic       isWord;
    logic       isSesqui;
    logic       isDouble;
    logic       isLong;
    logic       isRsvd;
    logic [2:0] longStep;
  } lenStrobes_t;
endpackage

// File: rtl/ild_ctrl.sv
module ild_ctrl
  import ild_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [PARCEL_W-1:0] parcelIn,
  input  logic                parcelValid,
  output lenStrobes_t         strobes
);
  always_comb begin
    strobes = '0;
    if (parcelValid) begin
      if (parcelIn[1:0] != 2'b11)           strobes.isShort  = 1'b1;
      else if (parcelIn[4:2] != 3'b111)     strobes.isWord   = 1'b1;
      else if (!parcelIn[5])                strobes.isSesqui = 1'b1;
      else if (!parcelIn[6])                strobes.isDouble = 1'b1;
      else if (parcelIn[14:12] == 3'b111)   strobes.isRsvd   = 1'b1;
      else begin
        strobes.isLong   = 1'b1;
        strobes.longStep = parcelIn[14:12];
      end
    end
  end

  // R2: every valid parcel falls into exactly one class
  p_one_class_r2: assert property (@(posedge clk) disable iff (!rstN)
    parcelValid |-> $onehot({strobes.isShort, strobes.isWord, strobes.isSesqui,
                             strobes.isDouble, strobes.isLong, strobes.isRsvd}));

  // R8: an idle input raises no strobe
  p_idle_strobes_r8: assert property (@(posedge clk) disable iff (!rstN)
    !parcelValid |-> (strobes == '0));
endmodule

// File: rtl/ild_dp.sv
module ild_dp
  import ild_pkg::*;
#(
  parameter int ILEN          = 64,
  parameter bit COMPRESSED_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  lenStrobes_t      strobes,
  output logic [LEN_W-1:0] lenParcels,
  output logic             isCompressed,
  output logic             isReserved,
  output logic             isIllegal
);
  localparam int MAX_PARCELS = ILEN / PARCEL_W;

  logic tooLong;
  logic shortBad;

  always_comb begin
    if (strobes.isShort)       lenParcels = LEN_W'(1);
    else if (strobes.isWord)   lenParcels = LEN_W'(2);
    else if (strobes.isSesqui) lenParcels = LEN_W'(3);
    else if (strobes.isDouble) lenParcels = LEN_W'(4);
    else if (strobes.isLong)   lenParcels = LEN_W'(5) + LEN_W'(strobes.longStep);
    else                       lenParcels = '0;
  end

  assign tooLong = (int'(lenParcels) > MAX_PARCELS);

  generate
    if (COMPRESSED_EN) begin : g_shortOk
      assign shortBad = 1'b0;
    end else begin : g_shortBad
      assign shortBad = strobes.isShort;
    end
  endgenerate

  assign isCompressed = strobes.isShort;
  assign isReserved   = strobes.isRsvd;
  assign isIllegal    = strobes.isRsvd | tooLong | shortBad;

  // R4: long encodings land on the 5..11 parcel rungs
  p_long_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.isLong |-> (lenParcels >= LEN_W'(5) && lenParcels <= LEN_W'(LADDER_MAX)));

  // R6: a length accepted as legal fits within ILEN
  p_legal_fits_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lenParcels != '0 && !isIllegal) |-> (int'(lenParcels) * PARCEL_W <= ILEN));
endmodule

// File: rtl/ild_oreg.sv
module ild_oreg
  import ild_pkg::*;
#(
  parameter bit OUT_REG = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] lenIn,
  input  logic             compIn,
  input  logic             rsvdIn,
  input  logic             illIn,
  input  logic             validIn,
  output logic [LEN_W-1:0] lenOut,
  output logic             compOut,
  output logic             rsvdOut,
  output logic             illOut,
  output logic             validOut
);
  localparam int BUNDLE_W = LEN_W + 4;

  logic [BUNDLE_W-1:0] bundleIn;
  logic [BUNDLE_W-1:0] bundleOut;

  assign bundleIn = {lenIn, compIn, rsvdIn, illIn, validIn};

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) bundleOut <= '0;
        else       bundleOut <= bundleIn;
      end
    end else begin : g_pass
      assign bundleOut = bundleIn;
    end
  endgenerate

  assign {lenOut, compOut, rsvdOut, illOut, validOut} = bundleOut;
endmodule

// File: rtl/ild_top.sv
module ild_top
  import ild_pkg::*;
#(
  parameter int ILEN          = 64,
  parameter bit COMPRESSED_EN = 1'b1,
  parameter bit OUT_REG       = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] parcelIn,
  input  logic        parcelValid,
  output logic [3:0]  lenParcels,
  output logic        isCompressed,
  output logic        isReserved,
  output logic        isIllegal,
  output logic        lenValid
);
  lenStrobes_t      strobes;
  logic [LEN_W-1:0] dpLen;
  logic             dpComp;
  logic             dpRsvd;
  logic             dpIll;

  ild_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .parcelIn(parcelIn),
    .parcelValid(parcelValid), .strobes(strobes)
  );

  ild_dp #(.ILEN(ILEN), .COMPRESSED_EN(COMPRESSED_EN)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lenParcels(dpLen),
    .isCompressed(dpComp), .isReserved(dpRsvd), .isIllegal(dpIll)
  );

  ild_oreg #(.OUT_REG(OUT_REG)) u_oreg (
    .clk(clk), .rstN(rstN),
    .lenIn(dpLen), .compIn(dpComp), .rsvdIn(dpRsvd), .illIn(dpIll),
    .validIn(parcelValid),
    .lenOut(lenParcels), .compOut(isCompressed), .rsvdOut(isReserved),
    .illOut(isIllegal), .validOut(lenValid)
  );

  // R5: reserved space never reports a usable length
  p_rsvd_len_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    isReserved |-> (lenParcels == '0 && isIllegal));

  // R1: the compressed flag always goes with a single-parcel length
  p_comp_one_parcel_r1: assert property (@(posedge clk) disable iff (!rstN)
    isCompressed |-> (lenParcels == 4'd1));

  // R8: no result is shown without valid
  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !lenValid |-> (lenParcels == '0 && !isCompressed && !isReserved && !isIllegal));

  generate
    if (OUT_REG) begin : g_latChk
      logic armed;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) armed <= 1'b0;
        else       armed <= 1'b1;
      end
      // R9: valid leaves one clock after it arrives
      p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rstN)
        armed |-> (lenValid == $past(parcelValid)));
    end else begin : g_combChk
      // R8: valid passes straight through
      p_same_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
        lenValid == parcelValid);
    end
  endgenerate
endmodule

// File: tb/ild_top_tb.sv
`timescale 1ns/1ps
module ild_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  // default instance: ILEN 64, compressed on, combinational
  logic [15:0] p1 = '0;
  logic        v1 = 1'b0;
  logic [3:0]  len1;
  logic        c1, r1, i1, vo1;

  // variant: ILEN 176, compressed off, registered
  logic [15:0] p2 = '0;
  logic        v2 = 1'b0;
  logic [3:0]  len2;
  logic        c2, r2, i2, vo2;

  ild_top u_dut (
    .clk(clk), .rstN(rstN), .parcelIn(p1), .parcelValid(v1),
    .lenParcels(len1), .isCompressed(c1), .isReserved(r1),
    .isIllegal(i1), .lenValid(vo1)
  );

  ild_top #(.ILEN(176), .COMPRESSED_EN(1'b0), .OUT_REG(1'b1)) u_dut2 (
    .clk(clk), .rstN(rstN), .parcelIn(p2), .parcelValid(v2),
    .lenParcels(len2), .isCompressed(c2), .isReserved(r2),
    .isIllegal(i2), .lenValid(vo2)
  );

  // {parcel, length, compressed, reserved, illegal} for ILEN = 64
  localparam int NV = 15;
  localparam logic [22:0] VEC [NV] = '{
    {16'h0000, 4'd1,  1'b1, 1'b0, 1'b0},  // R1
    {16'h0001, 4'd1,  1'b1, 1'b0, 1'b0},  // R1
    {16'hFFFE, 4'd1,  1'b1, 1'b0, 1'b0},  // R1 R10
    {16'h0003, 4'd2,  1'b0, 1'b0, 1'b0},  // R2
    {16'h0013, 4'd2,  1'b0, 1'b0, 1'b0},  // R2
    {16'hFFFB, 4'd2,  1'b0, 1'b0, 1'b0},  // R2 R10
    {16'h001F, 4'd3,  1'b0, 1'b0, 1'b0},  // R3
    {16'h8FDF, 4'd3,  1'b0, 1'b0, 1'b0},  // R3 R10
    {16'h003F, 4'd4,  1'b0, 1'b0, 1'b0},  // R3 R6 at limit
    {16'h503F, 4'd4,  1'b0, 1'b0, 1'b0},  // R3 R10
    {16'h007F, 4'd5,  1'b0, 1'b0, 1'b1},  // R4 R6
    {16'h107F, 4'd6,  1'b0, 1'b0, 1'b1},  // R4 R6
    {16'hE07F, 4'd11, 1'b0, 1'b0, 1'b1},  // R4 R6 R10
    {16'h707F, 4'd0,  1'b0, 1'b1, 1'b1},  // R5
    {16'hFFFF, 4'd0,  1'b0, 1'b1, 1'b1}   // R5 R10
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [15:0] p);
    if (p[1:0] != 2'b11)        return "R1";
    if (p[4:2] != 3'b111)       return "R2";
    if (p[6:5] != 2'b11)        return "R3";
    if (p[14:12] == 3'b111)     return "R5";
    return "R4/R6";
  endfunction

  task automatic chk2(input string req, input int eLen, input int eC, input int eR,
                      input int eI, input int eV);
    chk(req, "dut2 len", int'(len2), eLen);
    chk(req, "dut2 comp", int'(c2), eC);
    chk(req, "dut2 rsvd", int'(r2), eR);
    chk(req, "dut2 ill", int'(i2), eI);
    chk(req, "dut2 valid", int'(vo2), eV);
  endtask

  task automatic drive2(input logic [15:0] p, input logic v);
    @(negedge clk);
    p2 = p;
    v2 = v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    // reset: drive a parcel into the registered instance while held in reset
    p2 = 16'h0003;
    v2 = 1'b1;
    p1 = 16'h0003;
    v1 = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "reset len", int'(len2), 0);
    chk("R9", "reset valid", int'(vo2), 0);
    chk("R8", "idle len", int'(len1), 0);
    chk("R8", "idle valid", int'(vo1), 0);
    chk("R8", "idle comp", int'(c1), 0);
    @(negedge clk);
    rstN = 1'b1;
    v2 = 1'b0;

    // table walk on the combinational instance
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      p1 = VEC[k][22:7];
      v1 = 1'b1;
      #1;
      chk(reqOf(p1), "len", int'(len1), int'(VEC[k][6:3]));
      chk(reqOf(p1), "comp", int'(c1), int'(VEC[k][2]));
      chk(reqOf(p1), "rsvd", int'(r1), int'(VEC[k][1]));
      chk(reqOf(p1), "ill", int'(i1), int'(VEC[k][0]));
      chk("R8", "valid same cycle", int'(vo1), 1);
    end

    // R8: dropping valid blanks every output in the same cycle
    @(negedge clk);
    p1 = 16'h707F;
    v1 = 1'b0;
    #1;
    chk("R8", "blank len", int'(len1), 0);
    chk("R8", "blank rsvd", int'(r1), 0);
    chk("R8", "blank ill", int'(i1), 0);
    chk("R8", "blank valid", int'(vo1), 0);

    // registered instance, ILEN 176, compressed off
    drive2(16'h0003, 1'b1);
    chk2("R9", 2, 0, 0, 0, 1);
    // R9: new input is not visible before the next edge
    @(negedge clk);
    p2 = 16'h0001;
    v2 = 1'b1;
    #1;
    chk("R9", "held len", int'(len2), 2);
    chk("R9", "held comp", int'(c2), 0);
    @(posedge clk);
    #1;
    chk2("R7", 1, 1, 0, 1, 1);
    drive2(16'hFFFC, 1'b1);
    chk2("R7", 1, 1, 0, 1, 1);
    drive2(16'h607F, 1'b1);
    chk2("R4", 11, 0, 0, 0, 1);
    drive2(16'h307F, 1'b1);
    chk2("R4", 8, 0, 0, 0, 1);
    drive2(16'h707F, 1'b1);
    chk2("R5", 0, 0, 1, 1, 1);
    drive2(16'h607F, 1'b0);
    chk2("R9", 0, 0, 0, 0, 0);

    // R9: reset mid-stream clears the registered outputs
    drive2(16'h003F, 1'b1);
    chk2("R9", 4, 0, 0, 0, 1);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk2("R9", 0, 0, 0, 0, 0);
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule